// File: doc/BRIEF.md
# Daisy-Chainable Serial Loader for a 12-Bit Converter Code

This block is the digital front end of a 12-bit current-output converter. A host drives three wires: an active-low frame strobe, a serial clock and a data line. While the strobe is low, every capture edge of the serial clock moves one bit into a 16-bit shift register. The most significant bit is sent first. The top four bits of the word are control bits and the low twelve are the converter code. When the strobe returns high after a complete frame, the code is copied into an output latch. The interface is therefore double-buffered: the analog side only ever sees whole codes.

The three serial pins are oversampled by a faster system clock through two-flop synchronizers, and clock edges are found from the synchronized copy. The capture edge is the falling edge after reset. Control words can move it to the rising edge and back. The bit leaving the top of the shift register is driven on a serial output pin on the opposite clock edge, so several devices can share one strobe and one clock in a chain.

Top module: `dac_serial_loader`

## Requirements
- R1: A frame is sent most significant bit first. Word bits 11:0 are the code placed on `dac_code`, and word bits 15:12 are control bits.
- R2: Serial clock edges seen while `sync_n` is high do not shift the register, count toward a frame, or change any output.
- R3: After reset, bits are captured on the falling edge of `sclk`. A complete frame whose control bits are 4'b0111 selects rising-edge capture, and 4'b1011 selects falling-edge capture. Any other control value keeps the current edge. A new edge selection takes effect with the next frame.
- R4: `dac_code` changes only after a rising edge of `sync_n`. During a frame, it keeps the code from the last complete frame.
- R5: A frame that ends after fewer than 16 capture edges leaves `dac_code` and the edge selection unchanged.
- R6: A frame with more than 16 capture edges latches the last 16 bits received.
- R7: While `rst_n` is low, `dac_code`, `sdout` and the shift register are zero.
- R8: `sdout` changes only on the edge opposite the capture edge, and it then carries bit 15 of the shift register. A word clocked in therefore reappears on `sdout`, unchanged, 16 clocks later.
- R9: Every complete frame copies bits 11:0 into `dac_code`, whatever the control bits are, within 4 system clocks of the rising edge of `sync_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out for chaining |
| dac_code | output | 12 | Latched converter code |

## Verification
The hardest condition to reach is a switch of the capture edge. It needs one complete frame carrying the mode word, and then a frame driven with the opposite clock polarity. If that second frame were clocked on the wrong edge, it would land shifted by one bit. To reach it, the stimulus moves the idle level of `sclk` only while the strobe is high. It then sends a data word whose bits are asymmetric, so a misplaced bit shows up in the code. It also checks `sdout` after every return edge against a shadow copy of the shift register, so a wrong edge choice is caught bit by bit.

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              sdout,
  output logic [CODE_W-1:0] dac_code
);
  localparam int CTRL_W = WORD_W - CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CTRL_W-1:0] CMD_RISE = CTRL_W'(7);
  localparam logic [CTRL_W-1:0] CMD_FALL = CTRL_W'(11);
  localparam logic [CNT_W-1:0]  FULL     = CNT_W'(WORD_W);

  logic [SYNC_STAGES-1:0] sck_p, frm_p, din_p;
  logic sck_q, frm_q, rise_mode;
  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  wire sck = sck_p[SYNC_STAGES-1];
  wire frm = frm_p[SYNC_STAGES-1];
  wire din = din_p[SYNC_STAGES-1];
  wire sck_rise  = sck & ~sck_q;
  wire sck_fall  = ~sck & sck_q;
  wire cap_edge  = ~frm & (rise_mode ? sck_rise : sck_fall);
  wire ret_edge  = ~frm & (rise_mode ? sck_fall : sck_rise);
  wire frame_end = frm & ~frm_q;
  wire [CTRL_W-1:0] ctrl = sreg[WORD_W-1:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      frm_p <= '1;
      din_p <= '0;
      sck_q <= 1'b0;
      frm_q <= 1'b1;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-2:0], sclk};
      frm_p <= {frm_p[SYNC_STAGES-2:0], sync_n};
      din_p <= {din_p[SYNC_STAGES-2:0], sdin};
      sck_q <= sck;
      frm_q <= frm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (frm) begin
      cnt <= '0;
    end else if (cap_edge) begin
      sreg <= {sreg[WORD_W-2:0], din};
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdout <= 1'b0;
    else if (ret_edge) sdout <= sreg[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code  <= '0;
      rise_mode <= 1'b0;
    end else if (frame_end && cnt == FULL) begin
      dac_code <= sreg[CODE_W-1:0];
      if (ctrl == CMD_RISE) rise_mode <= 1'b1;
      else if (ctrl == CMD_FALL) rise_mode <= 1'b0;
    end
  end
endmodule

module dac_serial_loader_chk #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm,
  input logic              frame_end,
  input logic              ret_edge,
  input logic [WORD_W-1:0] sreg,
  input logic [CNT_W-1:0]  cnt,
  input logic              sdout,
  input logic [CODE_W-1:0] dac_code
);
  a_r4_code_only_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(dac_code));
  a_r5_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cnt != CNT_W'(WORD_W)) |=> $stable(dac_code));
  a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));
  a_r2_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frm) |-> $stable(sreg));
  a_r8_sdout_on_return_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ret_edge) |-> $stable(sdout));
  a_r8_sdout_from_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ret_edge |=> sdout == $past(sreg[WORD_W-1]));
endmodule

bind dac_serial_loader dac_serial_loader_chk #(
  .WORD_W(WORD_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frm(frm), .frame_end(frame_end),
  .ret_edge(ret_edge), .sreg(sreg), .cnt(cnt), .sdout(sdout),
  .dac_code(dac_code)
);

// File: tb/dac_serial_loader_tb_top.sv
module dac_serial_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic sdout;
  logic [11:0] dac_code;

  dac_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .dac_code(dac_code)
  );

  always #5 clk = ~clk;

  typedef struct { bit is_sdout; logic [11:0] exp; string req; } item_t;
  item_t q[$];
  event ev;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] mdl = '0;
  logic        mode_rise = 1'b0;
  logic [11:0] exp_code = '0;

  task automatic expect_now(input bit is_sd, input logic [11:0] e, input string r);
    item_t it;
    it.is_sdout = is_sd; it.exp = e; it.req = r;
    q.push_back(it);
    ->ev;
  endtask

  initial forever begin
    @(ev);
    while (q.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it = q.pop_front();
      act = it.is_sdout ? {11'd0, sdout} : dac_code;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s actual=%h expected=%h", it.req,
                 it.is_sdout ? "sdout" : "dac_code", act, it.exp);
      end
    end
  end

  // Sends n bits (MSB first) from bits; optional mid-frame code check.
  task automatic send(input logic [31:0] bits, input int n, input string req, input bit mid);
    logic idle;
    idle = mode_rise ? 1'b0 : 1'b1;
    sclk = idle; #50;
    sync_n = 1'b0; #50;
    for (int k = 0; k < n; k++) begin
      logic b;
      b = bits[n-1-k];
      sdin = b; #50;
      sclk = ~idle; mdl = {mdl[14:0], b}; #50;
      sclk = idle; #40;
      expect_now(1'b1, {11'd0, mdl[15]}, "R8");
      if (mid && k == 8) expect_now(1'b0, exp_code, "R4");
      #10;
    end
    sync_n = 1'b1; #40;
    if (n >= 16) begin
      exp_code = mdl[11:0];
      if (mdl[15:12] == 4'b0111) mode_rise = 1'b1;
      else if (mdl[15:12] == 4'b1011) mode_rise = 1'b0;
    end
    expect_now(1'b0, exp_code, req);
    #60;
  endtask

  initial begin
    #20;
    expect_now(1'b0, 12'h000, "R7");
    expect_now(1'b1, 12'h000, "R7");
    rst_n = 1'b1; #40;
    send(32'h0ABC, 16, "R1", 1'b1);
    send(32'h3FF, 10, "R5", 1'b0);
    send(32'hF0123, 20, "R6", 1'b0);
    sdin = 1'b1;
    for (int i = 0; i < 6; i++) begin sclk = ~sclk; #50; end
    expect_now(1'b0, exp_code, "R2");
    send(32'h0555, 16, "R2", 1'b0);
    send(32'h0777_0246, 32, "R8", 1'b0);
    send(32'h79A5, 16, "R9", 1'b0);
    send(32'h036C, 16, "R3", 1'b1);
    send(32'hB111, 16, "R3", 1'b0);
    send(32'h0F0F, 16, "R3", 1'b0);
    send(32'h3222, 16, "R9", 1'b0);
    send(32'h00AA, 16, "R3", 1'b0);
    send(32'h0C35, 16, "R1", 1'b0);
    rst_n = 1'b0; #40;
    mdl = '0; mode_rise = 1'b0; exp_code = '0;
    expect_now(1'b0, 12'h000, "R7");
    expect_now(1'b1, 12'h000, "R7");
    rst_n = 1'b1; #40;
    send(32'h0812, 16, "R7", 1'b0);
    #100;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule